// File: doc/BRIEF.md
# TDM Audio Link Frame Receiver

This block sits at the receiving end of a fixed-rate time-division serial audio link. One data line and one frame marker arrive with a bit clock. The receiver samples both on the falling edge of that clock. A frame opens with a 16-bit tag slot, during which the frame marker is high. Twelve 20-bit payload slots follow, so a frame is 256 bits long. Each tag bit states whether its payload slot carries data in the current frame.

The receiver locks to the rising edge of the frame marker and gathers the tag slot. From the tag word it decides which payloads to pass on. It delivers four streams: the two register-read status slots (address and data) and the two recorded PCM channels. Each stream has an output register and a one-cycle valid strobe. A payload is passed on only when the frame-valid tag bit and the slot's own tag bit are both set. Otherwise the payload is dropped and the output register keeps its old value. A pulse marks the last bit of every frame. A second pulse flags a frame marker that stayed high for any length other than the tag slot.

Top module: `tdm_link_rx`

## Requirements
- R1: After a synchronous reset, all payload outputs read zero and every strobe and flag is low.
- R2: Alignment is taken from the falling-edge sample in which the frame marker is first seen high after being low. That sample is frame bit 0. A new rising edge restarts alignment at any point, including in the middle of a frame. Every slot is received MSB first.
- R3: The status address is the payload of slot 1 (frame bits 16 to 35). Its strobe pulses on the sample of bit 35 when tag bits 15 and 14 are both 1.
- R4: The status data is the payload of slot 2 (frame bits 36 to 55). Its strobe pulses on the sample of bit 55 when tag bits 15 and 13 are both 1.
- R5: The left PCM channel is slot 3 (bits 56 to 75), gated by tag bit 12. The right PCM channel is slot 4 (bits 76 to 95), gated by tag bit 11. Each also needs tag bit 15. The strobes pulse on bits 75 and 95.
- R6: A slot whose own tag bit is 0 gives no strobe, and its output register keeps its previous value, even when the slot carries nonzero bits.
- R7: When tag bit 15 (frame valid) is 0, no payload strobe pulses in that frame, and all payload outputs hold.
- R8: The frame-done output pulses for exactly one cycle, on the sample of frame bit 255.
- R9: The framing-error output pulses for one cycle on the first low sample of the frame marker, when the number of high samples since its rise was not 16. The frame is still decoded by bit count.
- R10: Each strobe lasts one cycle, and no two of the four payload strobes or frame-done are ever high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bclk | input | 1 | Bit clock; all sampling and state changes on its falling edge |
| rst | input | 1 | Synchronous active-high reset |
| sdata | input | 1 | Serial data line |
| fsync | input | 1 | Frame marker, high during the tag slot |
| stat_addr | output | 20 | Last accepted slot 1 payload |
| stat_addr_vld | output | 1 | One-cycle strobe for stat_addr |
| stat_data | output | 20 | Last accepted slot 2 payload |
| stat_data_vld | output | 1 | One-cycle strobe for stat_data |
| pcm_l | output | 20 | Last accepted slot 3 payload |
| pcm_l_vld | output | 1 | One-cycle strobe for pcm_l |
| pcm_r | output | 20 | Last accepted slot 4 payload |
| pcm_r_vld | output | 1 | One-cycle strobe for pcm_r |
| frame_done | output | 1 | Pulse on the last bit of a frame |
| frame_err | output | 1 | Pulse when the frame marker high time was not 16 bits |

## Verification
The bench uses the default geometry: a 16-bit tag slot and twelve 20-bit slots. Each frame then takes 256 bench cycles, so full frames, a truncated frame followed by a realignment, and marker high times of 15 and 17 bits all fit in a short run. With these defaults, the exact bit indices of each strobe (35, 55, 75, 95) and of frame-done (255) are fixed numbers. The bench compares against them directly.

// File: rtl/tdm_link_rx.sv
module tdm_link_rx #(
  parameter int TAG_W  = 16,
  parameter int SLOT_W = 20,
  parameter int SLOTS  = 12
) (
  input  logic              bclk,
  input  logic              rst,
  input  logic              sdata,
  input  logic              fsync,
  output logic [SLOT_W-1:0] stat_addr,
  output logic              stat_addr_vld,
  output logic [SLOT_W-1:0] stat_data,
  output logic              stat_data_vld,
  output logic [SLOT_W-1:0] pcm_l,
  output logic              pcm_l_vld,
  output logic [SLOT_W-1:0] pcm_r,
  output logic              pcm_r_vld,
  output logic              frame_done,
  output logic              frame_err
);
  localparam int FRAME_BITS = TAG_W + SLOT_W * SLOTS;
  localparam int CW = $clog2(FRAME_BITS);
  localparam int PW = $clog2(SLOT_W);
  localparam int SW = $clog2(SLOTS + 1);
  localparam int HW = $clog2(TAG_W) + 2;

  logic              sync_q, active, in_data;
  logic [CW-1:0]     bitn;
  logic [PW-1:0]     pos;
  logic [SW-1:0]     slot;
  logic [TAG_W-1:0]  tag_sh, tag;
  logic [SLOT_W-1:0] sh;
  logic [HW-1:0]     hi_len;

  wire start    = fsync & ~sync_q;
  wire [SLOT_W-1:0] word = {sh[SLOT_W-2:0], sdata};
  wire slot_end = active && in_data && (pos == PW'(SLOT_W - 1));
  wire last_bit = active && (bitn == CW'(FRAME_BITS - 1));
  wire fvalid   = tag[TAG_W-1];
  wire take1 = !start && slot_end && slot == SW'(1) && fvalid && tag[TAG_W-2];
  wire take2 = !start && slot_end && slot == SW'(2) && fvalid && tag[TAG_W-3];
  wire take3 = !start && slot_end && slot == SW'(3) && fvalid && tag[TAG_W-4];
  wire take4 = !start && slot_end && slot == SW'(4) && fvalid && tag[TAG_W-5];

  always_ff @(negedge bclk) begin
    if (rst) begin
      sync_q  <= 1'b0;
      active  <= 1'b0;
      in_data <= 1'b0;
      bitn    <= '0;
      pos     <= '0;
      slot    <= '0;
      tag_sh  <= '0;
      tag     <= '0;
      sh      <= '0;
    end else begin
      sync_q <= fsync;
      if (start) begin
        active  <= 1'b1;
        in_data <= 1'b0;
        bitn    <= CW'(1);
        tag_sh  <= {{(TAG_W-1){1'b0}}, sdata};
      end else if (active) begin
        bitn <= bitn + CW'(1);
        if (last_bit) active <= 1'b0;
        if (!in_data) begin
          tag_sh <= {tag_sh[TAG_W-2:0], sdata};
          if (bitn == CW'(TAG_W - 1)) begin
            tag     <= {tag_sh[TAG_W-2:0], sdata};
            in_data <= 1'b1;
            pos     <= '0;
            slot    <= SW'(1);
          end
        end else begin
          sh <= word;
          if (pos == PW'(SLOT_W - 1)) begin
            pos  <= '0;
            slot <= slot + SW'(1);
          end else begin
            pos <= pos + PW'(1);
          end
        end
      end
    end
  end

  always_ff @(negedge bclk) begin
    if (rst) begin
      hi_len    <= '0;
      frame_err <= 1'b0;
    end else begin
      if (start)                     hi_len <= HW'(1);
      else if (fsync && hi_len != '1) hi_len <= hi_len + HW'(1);
      else if (!fsync)               hi_len <= '0;
      frame_err <= !fsync && sync_q && (hi_len != HW'(TAG_W));
    end
  end

  always_ff @(negedge bclk) begin
    if (rst) begin
      stat_addr <= '0;  stat_addr_vld <= 1'b0;
      stat_data <= '0;  stat_data_vld <= 1'b0;
      pcm_l     <= '0;  pcm_l_vld     <= 1'b0;
      pcm_r     <= '0;  pcm_r_vld     <= 1'b0;
      frame_done <= 1'b0;
    end else begin
      stat_addr_vld <= take1;
      stat_data_vld <= take2;
      pcm_l_vld     <= take3;
      pcm_r_vld     <= take4;
      frame_done    <= last_bit && !start;
      if (take1) stat_addr <= word;
      if (take2) stat_data <= word;
      if (take3) pcm_l     <= word;
      if (take4) pcm_r     <= word;
    end
  end

  a_r10_one_strobe: assert property (@(negedge bclk) disable iff (rst)
    $onehot0({stat_addr_vld, stat_data_vld, pcm_l_vld, pcm_r_vld, frame_done}));
  a_r8_done_single: assert property (@(negedge bclk) disable iff (rst)
    frame_done |=> !frame_done);
  a_r6_addr_hold: assert property (@(negedge bclk) disable iff (rst)
    !stat_addr_vld |-> $stable(stat_addr));
  a_r6_pcm_r_hold: assert property (@(negedge bclk) disable iff (rst)
    !pcm_r_vld |-> $stable(pcm_r));
  a_r9_err_on_fall: assert property (@(negedge bclk) disable iff (rst)
    frame_err |-> (!sync_q && $past(sync_q)));
  a_r7_frame_valid: assert property (@(negedge bclk) disable iff (rst)
    (stat_addr_vld || stat_data_vld || pcm_l_vld || pcm_r_vld) |-> fvalid);
  a_r3_addr_timing: assert property (@(negedge bclk) disable iff (rst)
    stat_addr_vld |-> (bitn == CW'(TAG_W + SLOT_W)));
endmodule

// File: tb/tdm_link_rx_test.sv
`timescale 1ns/1ps
module tdm_link_rx_test;
  logic clk = 1'b0, rst = 1'b1, sdata = 1'b0, fsync = 1'b0;
  logic [19:0] stat_addr, stat_data, pcm_l, pcm_r;
  logic stat_addr_vld, stat_data_vld, pcm_l_vld, pcm_r_vld, frame_done, frame_err;
  int checks = 0, errors = 0;
  int cnt[4], idx[4], done_cnt, done_idx, err_cnt;
  logic [19:0] val[4];

  always #2.5 clk = ~clk;

  tdm_link_rx uut (.bclk(clk), .rst(rst), .sdata(sdata), .fsync(fsync),
    .stat_addr(stat_addr), .stat_addr_vld(stat_addr_vld),
    .stat_data(stat_data), .stat_data_vld(stat_data_vld),
    .pcm_l(pcm_l), .pcm_l_vld(pcm_l_vld), .pcm_r(pcm_r), .pcm_r_vld(pcm_r_vld),
    .frame_done(frame_done), .frame_err(frame_err));

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic observe(input int b);
    if (stat_addr_vld) begin cnt[0]++; idx[0] = b; val[0] = stat_addr; end
    if (stat_data_vld) begin cnt[1]++; idx[1] = b; val[1] = stat_data; end
    if (pcm_l_vld)     begin cnt[2]++; idx[2] = b; val[2] = pcm_l;     end
    if (pcm_r_vld)     begin cnt[3]++; idx[3] = b; val[3] = pcm_r;     end
    if (frame_done)    begin done_cnt++; done_idx = b; end
    if (frame_err)     err_cnt++;
  endtask

  task automatic run_frame(input logic [15:0] tag, input logic [19:0] a, d, l, r,
                           input int hi, input int nbits);
    logic [255:0] f;
    f = {tag, a, d, l, r, {8{20'h5A5A5}}};
    for (int k = 0; k < 4; k++) begin cnt[k] = 0; idx[k] = -1; val[k] = '0; end
    done_cnt = 0; done_idx = -1; err_cnt = 0;
    for (int i = 0; i <= nbits; i++) begin
      @(posedge clk);
      if (i > 0) observe(i - 1);
      if (i < nbits) begin fsync = (i < hi); sdata = f[255-i]; end
      else begin fsync = 1'b0; sdata = 1'b0; end
    end
    @(posedge clk);
    observe(nbits);
  endtask

  task automatic t_reset;
    chk("R1", "addr", stat_addr, 0);
    chk("R1", "pcm_r", pcm_r, 0);
    chk("R1", "strobes", {stat_addr_vld, stat_data_vld, pcm_l_vld, pcm_r_vld, frame_done, frame_err}, 0);
  endtask

  task automatic t_full;
    run_frame(16'hF800, 20'hA5C3E, 20'h12345, 20'h80001, 20'hFEDCB, 16, 256);
    chk("R2", "addr msb-first value", val[0], 20'hA5C3E);
    chk("R3", "addr strobe count", cnt[0], 1);
    chk("R3", "addr strobe bit", idx[0], 35);
    chk("R4", "data value", val[1], 20'h12345);
    chk("R4", "data strobe bit", idx[1], 55);
    chk("R5", "left value", val[2], 20'h80001);
    chk("R5", "left strobe bit", idx[2], 75);
    chk("R5", "right value", val[3], 20'hFEDCB);
    chk("R5", "right strobe bit", idx[3], 95);
    chk("R8", "done count", done_cnt, 1);
    chk("R8", "done bit", done_idx, 255);
    chk("R9", "no error at 16", err_cnt, 0);
  endtask

  task automatic t_tag_clear;
    run_frame(16'hD000, 20'h0F0F0, 20'h77777, 20'h3C3C3, 20'h99999, 16, 256);
    chk("R6", "addr taken", cnt[0], 1);
    chk("R6", "addr value", stat_addr, 20'h0F0F0);
    chk("R6", "data dropped", cnt[1], 0);
    chk("R6", "data held", stat_data, 20'h12345);
    chk("R6", "left taken", val[2], 20'h3C3C3);
    chk("R6", "right dropped", cnt[3], 0);
    chk("R6", "right held", pcm_r, 20'hFEDCB);
  endtask

  task automatic t_no_valid;
    run_frame(16'h7800, 20'h11111, 20'h22222, 20'h33333, 20'h44444, 16, 256);
    chk("R7", "strobes", cnt[0] + cnt[1] + cnt[2] + cnt[3], 0);
    chk("R7", "addr held", stat_addr, 20'h0F0F0);
    chk("R7", "left held", pcm_l, 20'h3C3C3);
    chk("R8", "done still", done_cnt, 1);
  endtask

  task automatic t_sync_len;
    run_frame(16'hF800, 20'hABCDE, 20'h2, 20'h3, 20'h4, 15, 256);
    chk("R9", "short sync error", err_cnt, 1);
    chk("R9", "decode continues", val[0], 20'hABCDE);
    run_frame(16'hF800, 20'h1, 20'h2, 20'h3, 20'h4, 17, 256);
    chk("R9", "long sync error", err_cnt, 1);
  endtask

  task automatic t_resync;
    run_frame(16'hF800, 20'hCAFE1, 20'hBEEF2, 20'h0, 20'h0, 16, 60);
    chk("R2", "truncated no done", done_cnt, 0);
    run_frame(16'hF800, 20'h13579, 20'h2468A, 20'h55555, 20'hAAAAA, 16, 256);
    chk("R2", "realigned addr", val[0], 20'h13579);
    chk("R2", "realigned right bit", idx[3], 95);
    chk("R10", "one strobe each", cnt[0] + cnt[1] + cnt[2] + cnt[3], 4);
    chk("R8", "realigned done bit", done_idx, 255);
  endtask

  initial begin
    #(100000 * 5);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(posedge clk);
    t_reset();
    rst = 1'b0;
    repeat (2) @(posedge clk);
    t_full();
    t_tag_clear();
    t_no_valid();
    t_sync_len();
    t_resync();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule